// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block holds the current time and date as seven packed-BCD registers: seconds, minutes, hours, day of the week, day of the month, month and two-digit year. A one-second enable advances the seconds. Each wrap carries into the next field in the same clock cycle. A halt control freezes all counting. The hours register can run in 24-hour form, or in 12-hour form with a PM flag. The date rolls over at the true end of each month, and February gets its 29th day in leap years.

Software or a bus adapter loads any register through a simple write port: a strobe, a 3-bit register select and a data byte. Reserved high bits are cleared on the way in. All seven registers are always visible on dedicated output buses. The 1 Hz enable comes from outside, so the prescaler and oscillator are not part of this block.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the registers read seconds 00, minutes 00, hours 00 (24-hour form), weekday 01, date 01, month 01, year 00.
- R2: Seconds and minutes count in BCD from 00 to 59. A step advances the seconds, and 59 returns to 00 while advancing the next field in the same cycle.
- R3: A step happens only on a cycle with `tick_1hz`=1 and `osc_halt`=0. With `osc_halt`=1, or with no tick, every register holds its value.
- R4: With hours bit 6 = 0 (24-hour form), hours run 00 to 23 in BCD with bit 5 as the tens bit for 20 to 23. 23 returns to 00 and advances the day.
- R5: With hours bit 6 = 1 (12-hour form), bits 4:0 hold 01 to 12 and bit 5 = 1 means PM. 11 AM steps to 12 PM. 11 PM steps to 12 AM and advances the day. 12 steps to 01 with the PM flag kept.
- R6: The weekday counts 01 to 07 and wraps from 07 to 01 on the cycle the day advances.
- R7: The date returns to 01 and the month advances after day 30 in months 04, 06, 09 and 11, and after day 31 in all other months. Month 12 returns to 01 and advances the year. Year 99 returns to 00.
- R8: February ends on day 29 when the year's value is divisible by 4 (including 00), and on day 28 otherwise.
- R9: A write with `wr_en`=1 loads the register selected by `wr_addr`: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year. The data is ANDed with 7F, 7F, 7F, 07, 3F, 1F, FF respectively. A write to select 7 changes nothing.
- R10: A write on the same cycle as a step gives the written register the written value. The other registers still advance, with carries taken from the values held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| osc_halt | input | 1 | 1 stops timekeeping |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select for the write |
| wr_data | input | 8 | Write data (BCD) |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours with format and PM/tens bit |
| wday_o | output | 8 | Day of week |
| date_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year |

## Verification
The rare situations are the carries at the end of a month or year, and in particular the February 28/29 decision. Reaching them by ticking would take months of simulated seconds. The stimulus therefore loads a full time-and-date state one cycle before the event through the write port, then applies one tick and compares all seven registers. This covers 30-day, 31-day, leap and non-leap Februaries, the year wrap, and both 12-hour boundaries. A write placed on the same cycle as a carrying tick shows that the carry is taken from the old value while the written register keeps the new one.

// File: rtl/bcdt_pkg.sv
package bcdt_pkg;
  localparam int REG_W   = 8;
  localparam int ADDR_W  = 3;
  localparam int NUM_REG = 7;

  typedef enum logic [ADDR_W-1:0] {
    SEL_SEC   = 3'd0,
    SEL_MIN   = 3'd1,
    SEL_HOUR  = 3'd2,
    SEL_WDAY  = 3'd3,
    SEL_DATE  = 3'd4,
    SEL_MONTH = 3'd5,
    SEL_YEAR  = 3'd6
  } reg_sel_e;

  // Increment a two-digit BCD value (caller handles the wrap point)
  function automatic logic [REG_W-1:0] bcd_inc(input logic [REG_W-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [REG_W-1:0] bcd_to_bin(input logic [REG_W-1:0] v);
    return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
  endfunction

  function automatic logic leap_year(input logic [REG_W-1:0] y);
    logic [REG_W-1:0] b;
    b = bcd_to_bin(y);
    return b[1:0] == 2'b00;
  endfunction

  // Last valid date of a month, in BCD
  function automatic logic [REG_W-1:0] month_last(input logic [REG_W-1:0] m,
                                                  input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // Next hours value; bit 8 of the result is the day carry
  function automatic logic [REG_W:0] hour_next(input logic [REG_W-1:0] h);
    logic [REG_W-1:0] n;
    logic [4:0]       v;
    logic             pm;
    v  = h[4:0];
    pm = h[5];
    if (h[6]) begin
      if (v == 5'h12)      return {1'b0, 2'b01, pm, 5'h01};
      else if (v == 5'h11) return {pm, 2'b01, ~pm, 5'h12};
      else begin
        n = bcd_inc({3'b000, v});
        return {1'b0, 2'b01, pm, n[4:0]};
      end
    end else begin
      if (h[5:0] == 6'h23) return {1'b1, 8'h00};
      else begin
        n = bcd_inc({2'b00, h[5:0]});
        return {1'b0, 2'b00, n[5:0]};
      end
    end
  endfunction

  // Writable bits per register
  function automatic logic [REG_W-1:0] wr_mask(input logic [ADDR_W-1:0] sel);
    case (sel)
      SEL_SEC, SEL_MIN, SEL_HOUR: return 8'h7F;
      SEL_WDAY:                   return 8'h07;
      SEL_DATE:                   return 8'h3F;
      SEL_MONTH:                  return 8'h1F;
      SEL_YEAR:                   return 8'hFF;
      default:                    return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/bcdt_base60.sv
module bcdt_base60
  import bcdt_pkg::*;
#(
  parameter logic [REG_W-1:0] LAST = 8'h59
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] val,
  output logic             wrap
);
  assign wrap = adv && (val >= LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)     val <= '0;
    else if (wr)    val <= wdata;
    else if (adv)   val <= wrap ? '0 : bcd_inc(val);
  end

  // R2
  rollover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr && val == LAST) |=> (val == 8'h00));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !wr) |=> $stable(val));

  // R10
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && adv) |=> (val == $past(wdata)));
endmodule

// File: rtl/bcdt_hour.sv
module bcdt_hour
  import bcdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] hour,
  output logic             day_adv
);
  logic [REG_W:0] nxt;

  assign nxt     = hour_next(hour);
  assign day_adv = adv && nxt[REG_W];

  always_ff @(posedge clk) begin
    if (!rst_n)   hour <= 8'h00;
    else if (wr)  hour <= wdata;
    else if (adv) hour <= nxt[REG_W-1:0];
  end

  // R4
  h24_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr && hour == 8'h23) |=> (hour == 8'h00));

  // R5
  pm_to_am_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr && hour == 8'h71) |=> (hour == 8'h52));

  // R5
  am_to_pm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr && hour == 8'h51) |=> (hour == 8'h72));

  // R4
  day_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    day_adv |-> (hour == 8'h23 || hour == 8'h71));
endmodule

// File: rtl/bcdt_calendar.sv
module bcdt_calendar
  import bcdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [3:0]       wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] wday,
  output logic [REG_W-1:0] date,
  output logic [REG_W-1:0] month,
  output logic [REG_W-1:0] year
);
  logic             leap;
  logic [REG_W-1:0] last_day;
  logic             mon_adv;
  logic             yr_adv;

  assign leap     = leap_year(year);
  assign last_day = month_last(month, leap);
  assign mon_adv  = adv && (date >= last_day);
  assign yr_adv   = mon_adv && (month >= 8'h12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wday  <= 8'h01;
      date  <= 8'h01;
      month <= 8'h01;
      year  <= 8'h00;
    end else begin
      if (wr[0])        wday  <= wdata;
      else if (adv)     wday  <= (wday >= 8'h07) ? 8'h01 : bcd_inc(wday);
      if (wr[1])        date  <= wdata;
      else if (adv)     date  <= mon_adv ? 8'h01 : bcd_inc(date);
      if (wr[2])        month <= wdata;
      else if (mon_adv) month <= yr_adv ? 8'h01 : bcd_inc(month);
      if (wr[3])        year  <= wdata;
      else if (yr_adv)  year  <= (year >= 8'h99) ? 8'h00 : bcd_inc(year);
    end
  end

  // R6
  wday_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr[0] && wday == 8'h07) |=> (wday == 8'h01));

  // R8
  feb_leap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wr == 4'b0 && month == 8'h02 && date == 8'h28 && leap)
      |=> (date == 8'h29 && month == 8'h02));

  // R7
  year_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wr == 4'b0 && month == 8'h12 && date == 8'h31)
      |=> (month == 8'h01 && date == 8'h01 && year != $past(year)));

  // R7
  short_month_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wr == 4'b0 && month == 8'h04 && date == 8'h30)
      |=> (month == 8'h05 && date == 8'h01));
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
  import bcdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              osc_halt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  sec_o,
  output logic [REG_W-1:0]  min_o,
  output logic [REG_W-1:0]  hour_o,
  output logic [REG_W-1:0]  wday_o,
  output logic [REG_W-1:0]  date_o,
  output logic [REG_W-1:0]  month_o,
  output logic [REG_W-1:0]  year_o
);
  localparam int NUM_SEXA = 2;

  logic                step;
  logic [NUM_REG-1:0]  wr_hit;
  logic [REG_W-1:0]    wdata_m;
  logic [NUM_SEXA:0]   sexa_adv;
  logic [REG_W-1:0]    sexa_val [NUM_SEXA];
  logic                day_adv;

  assign step    = tick_1hz && !osc_halt;
  assign wdata_m = wr_data & wr_mask(wr_addr);

  always_comb begin
    for (int k = 0; k < NUM_REG; k++)
      wr_hit[k] = wr_en && (wr_addr == ADDR_W'(k));
  end

  assign sexa_adv[0] = step;

  for (genvar i = 0; i < NUM_SEXA; i++) begin : g_sexa
    bcdt_base60 #(.LAST(8'h59)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (sexa_adv[i]),
      .wr    (wr_hit[i]),
      .wdata (wdata_m),
      .val   (sexa_val[i]),
      .wrap  (sexa_adv[i+1])
    );
  end

  bcdt_hour u_hour (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (sexa_adv[NUM_SEXA]),
    .wr      (wr_hit[SEL_HOUR]),
    .wdata   (wdata_m),
    .hour    (hour_o),
    .day_adv (day_adv)
  );

  bcdt_calendar u_cal (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (day_adv),
    .wr    (wr_hit[SEL_YEAR:SEL_WDAY]),
    .wdata (wdata_m),
    .wday  (wday_o),
    .date  (date_o),
    .month (month_o),
    .year  (year_o)
  );

  assign sec_o = sexa_val[0];
  assign min_o = sexa_val[1];

  // R3
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_halt && !wr_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)
                              && $stable(date_o) && $stable(year_o)));

  // R9
  no_hi_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (sec_o[7] == 1'b0 && min_o[7] == 1'b0 && hour_o[7] == 1'b0
         && wday_o[7:3] == 5'b0 && date_o[7:6] == 2'b0 && month_o[7:5] == 3'b0));
endmodule

// File: tb/bcd_timekeeper_bench.sv
module bcd_timekeeper_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;
  localparam int NVEC       = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       osc_halt = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_timekeeper u_bcd_timekeeper (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .osc_halt(osc_halt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o)
  );

  // {start sec,min,hour,wday,date,month,year ; expected after one tick}
  localparam logic [111:0] VEC [NVEC] = '{
    {56'h09_15_08_03_10_05_24, 56'h10_15_08_03_10_05_24}, // R2 units carry
    {56'h59_09_05_02_11_07_33, 56'h00_10_05_02_11_07_33}, // R2 minute tens
    {56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_01_00}, // R4 R6 R7 full roll
    {56'h59_59_23_02_30_04_21, 56'h00_00_00_03_01_05_21}, // R7 April
    {56'h59_59_23_04_28_02_23, 56'h00_00_00_05_01_03_23}, // R8 common year
    {56'h59_59_23_04_28_02_24, 56'h00_00_00_05_29_02_24}, // R8 leap year
    {56'h59_59_23_01_29_02_00, 56'h00_00_00_02_01_03_00}, // R8 year 00
    {56'h59_59_23_03_28_02_12, 56'h00_00_00_04_29_02_12}, // R8 tens odd leap
    {56'h59_59_23_03_28_02_19, 56'h00_00_00_04_01_03_19}, // R8 tens odd common
    {56'h59_59_51_03_15_06_10, 56'h00_00_72_03_15_06_10}, // R5 11 AM to 12 PM
    {56'h59_59_71_07_30_06_10, 56'h00_00_52_01_01_07_10}, // R5 R6 11 PM to 12 AM
    {56'h59_59_72_02_05_08_10, 56'h00_00_61_02_05_08_10}, // R5 12 PM to 01 PM
    {56'h59_59_49_02_05_08_10, 56'h00_00_50_02_05_08_10}, // R5 09 AM to 10 AM
    {56'h59_59_19_02_05_08_10, 56'h00_00_20_02_05_08_10}, // R4 19 to 20
    {56'h59_59_23_06_30_09_05, 56'h00_00_00_07_01_10_05}  // R7 September
  };

  function automatic logic [55:0] state();
    return {sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o};
  endfunction

  task automatic drive(input logic t, input logic h, input logic w,
                       input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    tick_1hz = t; osc_halt = h; wr_en = w; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    tick_1hz = 1'b0; osc_halt = 1'b0; wr_en = 1'b0;
  endtask

  task automatic load(input logic [55:0] st);
    for (int k = 0; k < 7; k++) drive(1'b0, 1'b0, 1'b1, 3'(k), st[55-8*k -: 8]);
  endtask

  task automatic check(input string req, input logic [55:0] exp);
    n_vec++;
    if (state() !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, state(), exp);
    end
  endtask

  task automatic check_byte(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG && !done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual %0d cycles expected fewer than %0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset", 56'h00_00_00_01_01_01_00);

    // Table walk: R2 R4 R5 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      load(VEC[v][111:56]);
      drive(1'b1, 1'b0, 1'b0, 3'd0, 8'h00);
      check($sformatf("R2/R4/R5/R6/R7/R8 vector %0d", v), VEC[v][55:0]);
    end

    // R3 halt and missing tick
    load(56'h30_20_10_04_12_03_15);
    drive(1'b1, 1'b1, 1'b0, 3'd0, 8'h00);
    check("R3 halted tick", 56'h30_20_10_04_12_03_15);
    drive(1'b0, 1'b0, 1'b0, 3'd0, 8'h00);
    check("R3 no tick", 56'h30_20_10_04_12_03_15);
    drive(1'b1, 1'b0, 1'b0, 3'd0, 8'h00);
    check("R3 resumed", 56'h31_20_10_04_12_03_15);

    // R9 masks on every register
    drive(1'b0, 1'b0, 1'b1, 3'd0, 8'hFF); check_byte("R9 sec mask",   sec_o,   8'h7F);
    drive(1'b0, 1'b0, 1'b1, 3'd1, 8'hFF); check_byte("R9 min mask",   min_o,   8'h7F);
    drive(1'b0, 1'b0, 1'b1, 3'd2, 8'hFF); check_byte("R9 hour mask",  hour_o,  8'h7F);
    drive(1'b0, 1'b0, 1'b1, 3'd3, 8'hFF); check_byte("R9 wday mask",  wday_o,  8'h07);
    drive(1'b0, 1'b0, 1'b1, 3'd4, 8'hFF); check_byte("R9 date mask",  date_o,  8'h3F);
    drive(1'b0, 1'b0, 1'b1, 3'd5, 8'hFF); check_byte("R9 month mask", month_o, 8'h1F);
    drive(1'b0, 1'b0, 1'b1, 3'd6, 8'hFF); check_byte("R9 year mask",  year_o,  8'hFF);
    load(56'h12_34_15_03_09_10_44);
    drive(1'b0, 1'b0, 1'b1, 3'd7, 8'h55);
    check("R9 select 7 ignored", 56'h12_34_15_03_09_10_44);

    // R10 write racing a tick
    load(56'h59_10_08_02_14_03_15);
    drive(1'b1, 1'b0, 1'b1, 3'd1, 8'h30);
    check("R10 minute write beats carry", 56'h00_30_08_02_14_03_15);
    drive(1'b1, 1'b0, 1'b1, 3'd0, 8'h20);
    check("R10 second write beats step", 56'h20_30_08_02_14_03_15);
    load(56'h59_59_23_02_31_03_15);
    drive(1'b1, 1'b0, 1'b1, 3'd4, 8'h05);
    check("R10 date write, month carry from old date", 56'h00_00_00_03_05_04_15);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule